// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests for an 8-bit controller core from five sources. Two external pins are active-low, so several open-drain sources can share one wire. Each pin can be set to respond to a low level or to a falling edge. The other three sources are two timer overflow flags and a serial port, whose transmit and receive flags together form one request. The controller masks each request with its own enable bit and a global enable. It splits the surviving requests into a high and a low group using a per-source priority bit. It then picks one request with a fixed polling order and drives a registered request line together with the service-routine address.

The core answers with an acknowledge pulse while the request is up, and with a return pulse when a service routine ends. The controller keeps track of which priority levels are in service. A low-priority routine can be interrupted by a high-priority request. Nothing can interrupt a high-priority routine, and a request never interrupts a routine of its own level. On acknowledge, a latched edge request is cleared inside the block. A timer request is cleared by a one-cycle pulse sent back to that timer. Serial flags and level requests stay until their owner removes them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While and after synchronous reset, `irq_req` is 0, `tmr_clr` is 0 and no level is in service.
- R2: Enable register `en_reg` gates source i with bit i: 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. Bit 7 is the global enable. A source whose bit is 0 does not request, and when bit 7 is 0 nothing requests.
- R3: Priority register `pri_reg` uses the same bit positions, and a 1 makes a source high priority. A pending high-priority source is chosen over any pending low-priority source.
- R4: Within one priority level, the lowest source index wins. The vector is 0x0003 + 8 × index: 0x0003, 0x000B, 0x0013, 0x001B, 0x0023.
- R5: External pins are active-low. `trig_mode` bit k selects the mode of pin k, where 0 means level and 1 means falling edge. In level mode a request is present while the sampled pin is low. In edge mode a falling edge latches a request that persists after the pin returns high.
- R6: On acknowledge of a timer source k, `tmr_clr` bit k pulses for exactly the next cycle. On acknowledge of an edge-mode external source, its latched request is cleared. Serial and level-mode requests are not cleared.
- R7: With nothing in service, any level may be granted. With low in service, only high requests are granted. With high in service, nothing is granted. Only an acknowledge marks a level in service.
- R8: A `reti` pulse ends the most recently entered level: high if high is in service, otherwise low.
- R9: `irq_req` and `irq_vec` are registered. A timer or serial flag raises `irq_req` after one clock edge, and an external falling edge after two. `irq_req` is 0 in the cycle after an accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 2 | Active-low external request pins |
| trig_mode | input | 2 | Per-pin trigger mode: 1 = falling edge, 0 = level |
| tmr_flag | input | 2 | Timer overflow flags |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| en_reg | input | 8 | Enable register (bits 0-4 sources, bit 7 global) |
| pri_reg | input | 8 | Priority register (bits 0-4, 1 = high) |
| ack | input | 1 | Core acknowledges the presented request |
| reti | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Service routine address |
| tmr_clr | output | 2 | One-cycle clear pulse for each timer flag |

## Verification
The hardest state to reach is the full two-deep nest: a low routine is interrupted by a high one, and while both are in service a further high request is held off. It must then be granted only after the first return, with the low request still waiting until the second return. Directed sequences build this state by acknowledging a low serial request, raising a high timer flag, and then raising a high external level while both levels are active. A second hard case is the cycle right after a timer acknowledge, when the timer has not yet dropped its flag. The random phase mixes enables, priorities and held levels with random acknowledges and returns, so that this cycle occurs at every nesting depth.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 5;
  localparam int IDX_W     = 3;
  localparam int NPAIR     = 2;   // external/timer pairs: pair k -> sources 2k, 2k+1
  localparam int GLOBAL_EN = 7;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;
endpackage

// File: rtl/irq_ext_input.sv
module irq_ext_input (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic pin_q;
  logic edge_flag;
  logic fall;

  assign fall = pin_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q     <= 1'b1;
      edge_flag <= 1'b0;
    end else begin
      pin_q     <= pin_n;
      edge_flag <= edge_mode & (fall | (edge_flag & ~clr));
    end
  end

  assign req = edge_mode ? edge_flag : ~pin_q;

  AST_LEVEL_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode && !$past(rst)) |-> (req == !$past(pin_n))); // R5
endmodule

// File: rtl/irq_poll_arbiter.sv
module irq_poll_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic [7:0]       en_reg,
  input  logic [7:0]       pri_reg,
  input  logic             insv_hi,
  input  logic             insv_lo,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic             sel_hi
);
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] hi_set;
  logic [NSRC-1:0] lo_set;
  logic [NSRC-1:0] cand;

  always_comb begin
    elig   = pend & en_reg[NSRC-1:0] & {NSRC{en_reg[GLOBAL_EN]}};
    hi_set = elig & pri_reg[NSRC-1:0];
    lo_set = elig & ~pri_reg[NSRC-1:0];
    if (insv_hi)       cand = '0;
    else if (|hi_set)  cand = hi_set;
    else if (insv_lo)  cand = '0;
    else               cand = lo_set;
    sel_hi = !insv_hi && (|hi_set);
    found  = |cand;
    idx    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic push_hi,
  input  logic pop,
  output logic insv_hi,
  output logic insv_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      insv_hi <= 1'b0;
      insv_lo <= 1'b0;
    end else if (push) begin
      if (push_hi) insv_hi <= 1'b1;
      else         insv_lo <= 1'b1;
    end else if (pop) begin
      if (insv_hi) insv_hi <= 1'b0;
      else         insv_lo <= 1'b0;
    end
  end

  AST_ENTER_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(insv_hi) || $rose(insv_lo)) |-> $past(push)); // R7
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       trig_mode,
  input  logic [1:0]       tmr_flag,
  input  logic             ser_tx,
  input  logic             ser_rx,
  input  logic [7:0]       en_reg,
  input  logic [7:0]       pri_reg,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [1:0]       tmr_clr
);
  logic [NSRC-1:0]  pend;
  logic [NPAIR-1:0] ext_req;
  logic [NPAIR-1:0] ext_clr;
  logic             found;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_hi;
  logic             insv_hi;
  logic             insv_lo;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;
  logic [IDX_W-1:0] idx_q;
  logic             hi_q;
  logic [NPAIR-1:0] tclr_q;
  logic             ack_ok;

  assign ack_ok = ack & req_q;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    irq_ext_input u_ext (
      .clk       (clk),
      .rst       (rst),
      .pin_n     (ext_n[k]),
      .edge_mode (trig_mode[k]),
      .clr       (ext_clr[k]),
      .req       (ext_req[k])
    );
    assign ext_clr[k]    = ack_ok && (idx_q == IDX_W'(2 * k));
    assign pend[2*k]     = ext_req[k];
    // a timer flag is masked while its clear pulse is out
    assign pend[2*k + 1] = tmr_flag[k] & ~tclr_q[k];
  end
  assign pend[SRC_SER] = ser_tx | ser_rx;

  irq_poll_arbiter u_arb (
    .pend    (pend),
    .en_reg  (en_reg),
    .pri_reg (pri_reg),
    .insv_hi (insv_hi),
    .insv_lo (insv_lo),
    .found   (found),
    .idx     (pick_idx),
    .sel_hi  (pick_hi)
  );

  irq_level_track u_lvl (
    .clk     (clk),
    .rst     (rst),
    .push    (ack_ok),
    .push_hi (hi_q),
    .pop     (reti),
    .insv_hi (insv_hi),
    .insv_lo (insv_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      vec_q  <= '0;
      idx_q  <= '0;
      hi_q   <= 1'b0;
      tclr_q <= '0;
    end else begin
      req_q <= ack_ok ? 1'b0 : found;
      vec_q <= VEC_W'(VEC_BASE) + VEC_W'(pick_idx) * VEC_W'(VEC_STEP);
      idx_q <= pick_idx;
      hi_q  <= pick_hi;
      for (int k = 0; k < NPAIR; k++) begin
        tclr_q[k] <= ack_ok && (idx_q == IDX_W'(2 * k + 1));
      end
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
  assign tmr_clr = tclr_q;

  AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_req) |=> !irq_req); // R9
  AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_reg[GLOBAL_EN] |=> !irq_req); // R2
  AST_NONE_OVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    insv_hi |-> !irq_req); // R7
  AST_CLR_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (rst)
    (|tmr_clr) |-> $past(ack)); // R6
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tmr_clr)); // R6
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  ext_n;
  logic [1:0]  trig_mode;
  logic [1:0]  tmr_flag;
  logic        ser_tx;
  logic        ser_rx;
  logic [7:0]  en_reg;
  logic [7:0]  pri_reg;
  logic        ack;
  logic        reti;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [1:0]  tmr_clr;

  int n_chk  = 0;
  int n_fail = 0;
  bit m_hi   = 0;
  bit m_lo   = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .ext_n(ext_n), .trig_mode(trig_mode),
    .tmr_flag(tmr_flag), .ser_tx(ser_tx), .ser_rx(ser_rx),
    .en_reg(en_reg), .pri_reg(pri_reg), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .tmr_clr(tmr_clr)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] vec_of(int idx);
    return 16'h0003 + 16'(idx) * 16'd8;
  endfunction

  function automatic int exp_idx(logic [4:0] p, logic [7:0] e, logic [7:0] r, bit h, bit l);
    logic [4:0] el, hs, ls, cand;
    el = p & e[4:0] & {5{e[7]}};
    hs = el & r[4:0];
    ls = el & ~r[4:0];
    if (h) cand = '0;
    else if (|hs) cand = hs;
    else if (l) cand = '0;
    else cand = ls;
    for (int i = 0; i < 5; i++) if (cand[i]) return i;
    return -1;
  endfunction

  task automatic expect_req(int idx, string tag);
    if (idx < 0) chk(irq_req == 1'b0, tag, 32'(irq_req), 0);
    else begin
      chk(irq_req == 1'b1, tag, 32'(irq_req), 1);
      chk(irq_vec == vec_of(idx), tag, 32'(irq_vec), 32'(vec_of(idx)));
    end
  endtask

  task automatic do_ack(int idx, bit lvl);
    logic [1:0] exp_clr;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk(irq_req == 1'b0, "R9 request drops after ack", 32'(irq_req), 0);
    exp_clr = (idx == 1) ? 2'b01 : (idx == 3) ? 2'b10 : 2'b00;
    chk(tmr_clr == exp_clr, "R6 timer clear pulse", 32'(tmr_clr), 32'(exp_clr));
    if (idx == 1) tmr_flag[0] = 1'b0;
    if (idx == 3) tmr_flag[1] = 1'b0;
    if (lvl) m_hi = 1; else m_lo = 1;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
    if (m_hi) m_hi = 0; else m_lo = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    rst = 1'b1; ext_n = 2'b11; trig_mode = 2'b00; tmr_flag = 2'b00;
    ser_tx = 0; ser_rx = 0; en_reg = 8'h9F; pri_reg = 8'h00; ack = 0; reti = 0;
    wait_n(3);
    chk(irq_req == 0, "R1 reset request", 32'(irq_req), 0);
    chk(tmr_clr == 0, "R1 reset clear", 32'(tmr_clr), 0);
    @(negedge clk); rst = 1'b0;
    wait_n(2);
    chk(irq_req == 0, "R1 idle after reset", 32'(irq_req), 0);

    // R9 latency of a timer flag, R6 clear pulse
    tmr_flag[0] = 1'b1;
    wait_n(1);
    expect_req(1, "R9 timer one-edge latency");
    do_ack(1, 0);
    do_reti();
    wait_n(3);
    expect_req(-1, "R6 timer cleared");

    // R5 edge mode on pin 0
    trig_mode = 2'b01; ext_n[0] = 1'b0;
    wait_n(1);
    expect_req(-1, "R9 edge not yet visible");
    wait_n(1);
    expect_req(0, "R5 falling edge latched");
    ext_n[0] = 1'b1;
    wait_n(3);
    expect_req(0, "R5 edge request held after pin high");
    do_ack(0, 0);
    do_reti();
    wait_n(3);
    expect_req(-1, "R6 edge request cleared on ack");

    // R5 level mode on pin 1
    trig_mode = 2'b00; ext_n[1] = 1'b0;
    wait_n(3);
    expect_req(2, "R5 level request");
    do_ack(2, 0);
    wait_n(3);
    expect_req(-1, "R7 same level blocked");
    do_reti();
    wait_n(3);
    expect_req(2, "R6 level request not cleared");
    do_ack(2, 0);
    ext_n[1] = 1'b1;
    do_reti();
    wait_n(3);
    expect_req(-1, "R5 level gone");

    // R2 enables
    ser_tx = 1'b1; en_reg = 8'h1F;
    wait_n(3);
    expect_req(-1, "R2 global enable off");
    en_reg = 8'h8F;
    wait_n(3);
    expect_req(-1, "R2 serial enable bit4 off");
    en_reg = 8'h9F;
    wait_n(3);
    expect_req(4, "R2 serial enabled");
    do_ack(4, 0);
    do_reti();
    wait_n(3);
    expect_req(4, "R6 serial flag not cleared");
    ser_tx = 1'b0; ser_rx = 1'b1;
    wait_n(3);
    expect_req(4, "R4 receive flag shares serial vector");
    ser_rx = 1'b0;

    // R4 polling order
    tmr_flag = 2'b11; ser_tx = 1'b1; ext_n = 2'b00;
    wait_n(3);
    expect_req(0, "R4 order ext0 first");
    en_reg = 8'h9E; wait_n(3); expect_req(1, "R4 order timer0 second");
    en_reg = 8'h9C; wait_n(3); expect_req(2, "R4 order ext1 third");
    en_reg = 8'h98; wait_n(3); expect_req(3, "R4 order timer1 fourth");
    en_reg = 8'h90; wait_n(3); expect_req(4, "R4 order serial last");

    // R3 priority
    en_reg = 8'h9F; pri_reg = 8'h10;
    wait_n(3); expect_req(4, "R3 high serial beats low sources");
    pri_reg = 8'h08;
    wait_n(3); expect_req(3, "R3 high timer1");

    // R7/R8 nesting
    tmr_flag = 2'b00; ext_n = 2'b11; ser_tx = 1'b1;
    wait_n(3); expect_req(4, "R7 idle grants low");
    do_ack(4, 0);
    wait_n(3); expect_req(-1, "R7 low blocks low");
    tmr_flag[1] = 1'b1;
    wait_n(3); expect_req(3, "R7 high over low");
    do_ack(3, 1);
    pri_reg = 8'h0C; ext_n[1] = 1'b0;
    wait_n(3); expect_req(-1, "R7 nothing over high");
    do_reti();
    wait_n(3); expect_req(2, "R8 pop high reopens high");
    do_ack(2, 1);
    ext_n[1] = 1'b1;
    do_reti();
    wait_n(3); expect_req(-1, "R8 low still in service");
    do_reti();
    wait_n(3); expect_req(4, "R8 second return frees low");
    do_ack(4, 0);
    ser_tx = 1'b0;
    do_reti();
    wait_n(3); expect_req(-1, "R8 all idle");

    // random phase (level mode)
    for (int it = 0; it < 400; it++) begin
      int e;
      logic [4:0] p;
      en_reg   = {($urandom % 4 != 0), 2'b00, 5'($urandom)};
      pri_reg  = {3'b000, 5'($urandom)};
      tmr_flag = 2'($urandom);
      ser_tx   = ($urandom % 3 == 0);
      ser_rx   = ($urandom % 3 == 0);
      ext_n    = 2'($urandom);
      wait_n(3);
      p = {ser_tx | ser_rx, tmr_flag[1], ~ext_n[1], tmr_flag[0], ~ext_n[0]};
      e = exp_idx(p, en_reg, pri_reg, m_hi, m_lo);
      expect_req(e, "R4 random arbitration");
      if (e >= 0 && ($urandom % 2 == 0)) do_ack(e, pri_reg[e]);
      else if ((m_hi || m_lo) && ($urandom % 3 == 0)) do_reti();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule